// File: doc/BRIEF.md
# Handshaked Eight-Bit ALU Core

This block is a small clocked arithmetic and logic unit. It takes two unsigned operands and a three-bit opcode. A requester raises `start` and keeps it high until `done` pulses, then reads `result` and drops `start`. The unit can add, AND, XOR or multiply the operands into a result twice the operand width. Add, AND and XOR finish at the edge that accepts the request. Multiply runs as a short shift-and-add sequence over several clock edges.

Two further codes have special meaning. A no-operation code is accepted without any completion. A clear code empties the result register. Both are sent with a one-cycle `start`, and the requester checks no result for them. The reset is synchronous and active low.

Top module: `hs_alu_core`

## Requirements
- R1: While `rst_n` is sampled low on two consecutive rising edges, the unit returns to idle. This holds even in the middle of a multiply. `done` then reads 0 and `result` reads 0, and the next request is accepted normally.
- R2: Opcode 001 (add) yields the full 9-bit sum of the operands, zero-extended to 16 bits.
- R3: Opcode 010 (AND) and opcode 011 (XOR) yield the bitwise result in bits 7:0, with bits 15:8 at zero.
- R4: For add, AND and XOR, `done` is high in the cycle that follows the rising edge at which `start` was first sampled high.
- R5: Opcode 100 (multiply) yields the full 16-bit product, so FF times FF gives FE01. `done` rises at the third rising edge, counting the accepting edge as the first.
- R6: `done` is high for exactly one cycle. `result` keeps its value until the next operation completes or a clear is accepted.
- R7: Operands and opcode are taken at the accepting edge. Changing them while a multiply is in flight does not change its result.
- R8: Opcodes 000, 101 and 110 produce no `done` and leave `result` unchanged.
- R9: Opcode 111, when accepted, sets `result` to 0 and produces no `done`.
- R10: After a request is accepted, no further request is accepted until `start` has been sampled low. A `start` held high after `done` therefore produces no second `done` and does not change `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 8 | First unsigned operand |
| opnd_b | input | 8 | Second unsigned operand |
| opcode | input | 3 | Operation select |
| start | input | 1 | Request, held until `done` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Last completed result |

## Verification
The bench biases its operands toward 00 and FF. At those values a truncated sum loses the carry into bit 8, and a multiply with a missing partial-product chunk gives a product other than FE01. It counts the edges from acceptance to `done`, so a multiply that finishes one edge early or late is reported, as is a single-cycle operation whose `done` is delayed. It scrambles the operands and opcode during a multiply; a design that reads the live ports returns the wrong product. Other directed cases keep `start` high after `done`, send the three no-operation codes and the clear code, and reset in the middle of a multiply. These catch a repeated `done`, a `result` changed without completion, and a result that survives reset.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OPC_NOP  = 3'b000,
    OPC_ADD  = 3'b001,
    OPC_AND  = 3'b010,
    OPC_XOR  = 3'b011,
    OPC_MUL  = 3'b100,
    OPC_NOP5 = 3'b101,
    OPC_NOP6 = 3'b110,
    OPC_CLR  = 3'b111
  } opc_e;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_ONE  = 2'd1,
    K_MUL  = 2'd2,
    K_CLR  = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_MUL  = 2'd1,
    S_REL  = 2'd2
  } ctrl_st_e;

  // Map an opcode onto the kind of work the controller must start.
  function automatic op_kind_e classify(input logic [2:0] opc);
    op_kind_e k;
    case (opc)
      OPC_ADD, OPC_AND, OPC_XOR: k = K_ONE;
      OPC_MUL:                   k = K_MUL;
      OPC_CLR:                   k = K_CLR;
      default:                   k = K_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int DW = 8,
  parameter int RW = 2 * DW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    opc,
  output logic [RW-1:0] y
);
  import alu_pkg::*;

  // Full-width sum: carry lands in bit DW, upper bits zero.
  function automatic logic [RW-1:0] sum_ext(input logic [DW-1:0] x, input logic [DW-1:0] z);
    logic [DW:0] s;
    s = {1'b0, x} + {1'b0, z};
    return RW'(s);
  endfunction

  function automatic logic [RW-1:0] and_ext(input logic [DW-1:0] x, input logic [DW-1:0] z);
    return RW'(x & z);
  endfunction

  function automatic logic [RW-1:0] xor_ext(input logic [DW-1:0] x, input logic [DW-1:0] z);
    return RW'(x ^ z);
  endfunction

  always_comb begin
    case (opc)
      OPC_ADD: y = sum_ext(a, b);
      OPC_AND: y = and_ext(a, b);
      OPC_XOR: y = xor_ext(a, b);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu_mul_seq.sv
module alu_mul_seq #(
  parameter int DW  = 8,
  parameter int LAT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic            busy,
  output logic            fin,
  output logic [2*DW-1:0] prod
);
  localparam int PWD   = 2 * DW;
  localparam int STEPS = LAT - 1;
  localparam int CH    = (DW + STEPS - 1) / STEPS;
  localparam int BW    = CH * STEPS;
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [DW-1:0]  mcand_q;
  logic [BW-1:0]  mplier_q;
  logic [BW-1:0]  b_pad;
  logic [PWD-1:0] acc_q;
  logic [SW-1:0]  step_q;
  logic           busy_q;
  logic [CH-1:0]  chunk;
  logic [PWD-1:0] part;
  logic           last_step;

  generate
    if (BW > DW) begin : g_pad
      assign b_pad = {{(BW-DW){1'b0}}, b};
    end else begin : g_nopad
      assign b_pad = b;
    end
  endgenerate

  // Multiplicand times one multiplier chunk, shift-and-add form.
  function automatic logic [PWD-1:0] chunk_mul(input logic [DW-1:0] m, input logic [CH-1:0] c);
    logic [PWD-1:0] s;
    s = '0;
    for (int i = 0; i < CH; i++) begin
      if (c[i]) s = s + (PWD'(m) << i);
    end
    return s;
  endfunction

  always_comb begin
    chunk     = mplier_q[int'(step_q)*CH +: CH];
    part      = chunk_mul(mcand_q, chunk) << (int'(step_q) * CH);
    last_step = (step_q == SW'(STEPS - 1));
  end

  assign busy = busy_q;
  assign fin  = busy_q && last_step;
  assign prod = acc_q + part;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      step_q   <= '0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (load) begin
      busy_q   <= 1'b1;
      step_q   <= '0;
      acc_q    <= '0;
      mcand_q  <= a;
      mplier_q <= b_pad;
    end else if (busy_q) begin
      if (last_step) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
        acc_q  <= acc_q + part;
      end
    end
  end

endmodule

// File: rtl/alu_seq_ctrl.sv
module alu_seq_ctrl (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  alu_pkg::op_kind_e kind,
  input  logic              mul_fin,
  output logic              take,
  output logic              fire_one,
  output logic              fire_mul,
  output logic              fire_clr,
  output logic              fire_nop,
  output logic              armed
);
  import alu_pkg::*;

  ctrl_st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    take     = 1'b0;
    fire_one = 1'b0;
    fire_mul = 1'b0;
    fire_clr = 1'b0;
    fire_nop = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          take = 1'b1;
          case (kind)
            K_ONE: begin fire_one = 1'b1; st_d = S_REL; end
            K_MUL: begin fire_mul = 1'b1; st_d = S_MUL; end
            K_CLR: begin fire_clr = 1'b1; st_d = S_REL; end
            default: begin fire_nop = 1'b1; st_d = S_REL; end
          endcase
        end
      end
      S_MUL: if (mul_fin) st_d = S_REL;
      S_REL: if (!start) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign armed = (st_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/hs_alu_core.sv
module hs_alu_core #(
  parameter int DW      = 8,
  parameter int MUL_LAT = 3,
  localparam int RW     = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [2:0]    opcode,
  input  logic          start,
  output logic          done,
  output logic [RW-1:0] result
);
  import alu_pkg::*;

  op_kind_e      kind;
  logic          take, fire_one, fire_mul, fire_clr, fire_nop, armed;
  logic          mul_busy, mul_fin;
  logic [RW-1:0] mul_prod, one_y;
  logic          done_q;
  logic [RW-1:0] result_q;

  assign kind = classify(opcode);

  alu_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .kind     (kind),
    .mul_fin  (mul_fin),
    .take     (take),
    .fire_one (fire_one),
    .fire_mul (fire_mul),
    .fire_clr (fire_clr),
    .fire_nop (fire_nop),
    .armed    (armed)
  );

  alu_logic_unit #(.DW(DW), .RW(RW)) u_one (
    .a   (opnd_a),
    .b   (opnd_b),
    .opc (opcode),
    .y   (one_y)
  );

  alu_mul_seq #(.DW(DW), .LAT(MUL_LAT)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire_mul),
    .a     (opnd_a),
    .b     (opnd_b),
    .busy  (mul_busy),
    .fin   (mul_fin),
    .prod  (mul_prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= fire_one | mul_fin;
      if (fire_one)      result_q <= one_y;
      else if (mul_fin)  result_q <= mul_prod;
      else if (fire_clr) result_q <= '0;
    end
  end

  assign done   = done_q;
  assign result = result_q;

endmodule

// File: rtl/hs_alu_core_chk.sv
module hs_alu_core_chk #(
  parameter int MUL_LAT = 3,
  parameter int RW      = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [RW-1:0] result,
  input logic          take,
  input logic          fire_one,
  input logic          fire_mul,
  input logic          fire_clr,
  input logic          fire_nop,
  input logic          mul_fin
);
  localparam int AW = $clog2(MUL_LAT + 2);
  logic [AW-1:0] mul_age;

  always_ff @(posedge clk) begin
    if (!rst_n)             mul_age <= '0;
    else if (fire_mul)      mul_age <= AW'(1);
    else if (mul_fin)       mul_age <= '0;
    else if (mul_age != '0) mul_age <= mul_age + 1'b1;
  end

  assert_single_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_one |=> done);

  assert_mul_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fin |-> (mul_age == AW'(MUL_LAT - 1)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(fire_clr)) |-> $stable(result));

  assert_nop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_nop |=> !done);

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_clr |=> (result == '0 && !done));

  assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

endmodule

bind hs_alu_core hs_alu_core_chk #(.MUL_LAT(MUL_LAT), .RW(RW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .result   (result),
  .take     (take),
  .fire_one (fire_one),
  .fire_mul (fire_mul),
  .fire_clr (fire_clr),
  .fire_nop (fire_nop),
  .mul_fin  (mul_fin)
);

// File: tb/sim_hs_alu_core.sv
`timescale 1ns/1ps
module sim_hs_alu_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  opnd_a, opnd_b;
  logic [2:0]  opcode;
  logic        start;
  logic        done;
  logic [15:0] result;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;
  logic [15:0] model_res = 16'h0;

  hs_alu_core u0 (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .opcode(opcode), .start(start), .done(done), .result(result)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference result computed from the requirements.
  function automatic logic [15:0] ref_calc(input logic [7:0] a, input logic [7:0] b,
                                           input logic [2:0] op, input logic [15:0] prev);
    logic [15:0] r;
    case (op)
      3'd1: r = 16'(a) + 16'(b);
      3'd2: r = {8'h00, a & b};
      3'd3: r = {8'h00, a ^ b};
      3'd4: begin
        r = 16'h0;
        for (int i = 0; i < 8; i++) if (b[i]) r = r + (16'(a) << i);
      end
      3'd7: r = 16'h0;
      default: r = prev;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] pick_data();
    int unsigned s = $urandom % 4;
    if (s == 0) return 8'h00;
    if (s == 3) return 8'hFF;
    return 8'($urandom);
  endfunction

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                        input bit hold_after, input bit scramble);
    int lat;
    logic [15:0] exp;
    string tg;
    exp = ref_calc(a, b, op, model_res);
    lat = (op == 3'd1 || op == 3'd2 || op == 3'd3) ? 1 : (op == 3'd4) ? 3 : 0;
    tg  = (op == 3'd1) ? "R2" : (op == 3'd4) ? "R5" : (op == 3'd7) ? "R9" :
          (lat == 1) ? "R3" : "R8";
    @(negedge clk);
    opnd_a = a; opnd_b = b; opcode = op; start = 1'b1;
    if (lat == 0) begin
      @(posedge clk); #1;
      start = 1'b0;
      chk(done == 1'b0, {tg, " no done"}, 16'(done), 16'h0);
      chk(result == exp, {tg, " result"}, result, exp);
      @(posedge clk); #1;
      chk(done == 1'b0, {tg, " no late done"}, 16'(done), 16'h0);
    end else begin
      for (int i = 1; i <= lat; i++) begin
        @(posedge clk); #1;
        if (scramble && i == 1) begin
          opnd_a = ~a; opnd_b = b + 8'd3; opcode = 3'd1;
        end
        if (i < lat) chk(done == 1'b0, "R5 early done", 16'(done), 16'h0);
      end
      chk(done == 1'b1, (lat == 1) ? "R4 done timing" : "R5 done timing", 16'(done), 16'h1);
      chk(result == exp, scramble ? {tg, "/R7 result"} : {tg, " result"}, result, exp);
      if (hold_after) begin
        for (int i = 0; i < 2; i++) begin
          @(posedge clk); #1;
          chk(done == 1'b0, "R10 held start no done", 16'(done), 16'h0);
          chk(result == exp, "R10 held start result", result, exp);
        end
      end
      start = 1'b0;
      @(posedge clk); #1;
      chk(done == 1'b0, "R6 pulse width", 16'(done), 16'h0);
      chk(result == exp, "R6 result hold", result, exp);
    end
    model_res = exp;
  endtask

  initial begin
    #1_000_000;
    if (!ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; opnd_a = '0; opnd_b = '0; opcode = '0;
    repeat (2) @(posedge clk);
    #1;
    chk(done == 1'b0, "R1 reset done", 16'(done), 16'h0);
    chk(result == 16'h0, "R1 reset result", result, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // Directed corner cases
    run_op(8'hFF, 8'hFF, 3'd1, 0, 0);   // R2 carry into bit 8
    run_op(8'hFF, 8'hFF, 3'd4, 0, 0);   // R5 FE01
    run_op(8'hA5, 8'h0F, 3'd2, 0, 0);   // R3 and
    run_op(8'hA5, 8'hFF, 3'd3, 0, 0);   // R3 xor
    run_op(8'h00, 8'hFF, 3'd4, 1, 0);   // R10 hold after done
    run_op(8'hD3, 8'h7B, 3'd4, 0, 1);   // R7 scramble in flight
    run_op(8'h12, 8'h34, 3'd0, 0, 0);   // R8
    run_op(8'h12, 8'h34, 3'd5, 0, 0);   // R8
    run_op(8'h12, 8'h34, 3'd6, 0, 0);   // R8
    run_op(8'h80, 8'h80, 3'd1, 1, 0);   // R10 on single op
    run_op(8'h55, 8'h66, 3'd7, 0, 0);   // R9 clear

    // R1: reset in the middle of a multiply
    run_op(8'h0F, 8'h0E, 3'd1, 0, 0);
    @(negedge clk);
    opnd_a = 8'hFF; opnd_b = 8'hFF; opcode = 3'd4; start = 1'b1;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(done == 1'b0, "R1 mid-mul reset done", 16'(done), 16'h0);
    chk(result == 16'h0, "R1 mid-mul reset result", result, 16'h0);
    @(negedge clk); rst_n = 1'b1; start = 1'b0;
    @(posedge clk); #1;
    chk(done == 1'b0, "R1 no stale done", 16'(done), 16'h0);
    model_res = 16'h0;
    run_op(8'h20, 8'h21, 3'd1, 0, 0);   // R1 accepts after reset

    // Random mix biased to 00 and FF
    for (int k = 0; k < 300; k++) begin
      logic [2:0] op;
      op = 3'($urandom);
      run_op(pick_data(), pick_data(), op, ($urandom % 5) == 0, ($urandom % 4) == 0);
    end

    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule